// File: doc/BRIEF.md
# Power and Reset Control Sequencer

This block sits behind a write-only system power control register. A write presents a control byte. In that byte, one bit requests power off, three bits request different kinds of reboot or memory reset, and one bit notifies the block that sleep is about to be entered. When a reset request is accepted, the sequencer pulls a chosen subset of three active-low reset lines low. The lines are a global reset, a secondary reset and a memory reset. While the secondary reset is held, its pin is driven as an output.

A millisecond tick input times the sequence. The reset lines stay low for a fixed number of ticks and are then all released together, and the secondary pin returns to input mode. A second, longer interval then follows. At its end a one-cycle re-initialise pulse is sent out and the sequencer returns to idle. A normal reboot also asserts the memory reset when the legacy emulation input is high, and it pulses a clear for the legacy register set. Power off and the external watchdog are represented only as strobes.

Top module: `power_reset_seq`

## Requirements
- R1: After reset, globalRstN, secRstN and memRstN are 1, secOe is 0, and powerOffPulse, legacyClr, reinitPulse and sleepFlag are all 0.
- R2: An accepted write with bit 1 set (full reboot) drives globalRstN, secRstN and memRstN to 0 and secOe to 1 in the cycle after the write.
- R3: An accepted write whose highest-priority request is bit 2 (normal reboot) drives secRstN to 0 and secOe to 1, and leaves globalRstN at 1. It drives memRstN to 0 only if legacyMode is 1, and it gives a one-cycle legacyClr pulse.
- R4: An accepted write whose highest-priority request is bit 3 (memory reset) drives only memRstN to 0, and secOe stays 0.
- R5: An accepted write with bit 0 set gives a one-cycle powerOffPulse, asserts no reset line and starts no sequence, whatever other bits are set.
- R6: Among the reset requests, bit 1 beats bit 2, and bit 2 beats bit 3.
- R7: The asserted lines are all released together, and secOe returns to 0, in the cycle after the ASSERT_MS-th msTick that follows the write (default 5).
- R8: reinitPulse is high for exactly one cycle, in the cycle after the REINIT_MS-th msTick that follows the release (default 100). The block is then idle.
- R9: A reset or power-off write that arrives before the re-initialise pulse has no effect on the reset lines or the strobes.
- R10: Bit 4 sets the sticky sleepFlag and causes no reset action. Bits 7:5 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous block reset |
| ctrlWrEn | input | 1 | Control register write strobe |
| ctrlWrData | input | 8 | Control byte |
| msTick | input | 1 | One-cycle millisecond tick |
| legacyMode | input | 1 | Legacy emulation mode active |
| globalRstN | output | 1 | Global reset, active low |
| secRstN | output | 1 | Secondary reset, active low |
| secOe | output | 1 | Secondary reset pin direction, 1 = output |
| memRstN | output | 1 | Memory reset, active low |
| powerOffPulse | output | 1 | Power-off strobe |
| legacyClr | output | 1 | Legacy register set clear strobe |
| reinitPulse | output | 1 | Re-initialise strobe |
| sleepFlag | output | 1 | Sticky sleep-entry watchdog-state flag |

## Verification
A wrong request decode shows up on the reset lines and strobes one cycle after the write, as the wrong subset of low lines or a missing strobe. A wrong tick count moves the release edge or the re-initialise pulse by a whole millisecond, so it is seen at the tick where the bench expects the change. A sequencer that does not return to idle, or that leaves idle too early, shows up either as an ignored request that takes effect or as a valid request that is lost after the pulse.

// File: rtl/prc_pkg.sv
package prc_pkg;
  localparam int BIT_POFF   = 0;
  localparam int BIT_FULL   = 1;
  localparam int BIT_NORMAL = 2;
  localparam int BIT_MEM    = 3;
  localparam int BIT_SLEEP  = 4;

  localparam int LINE_GLB = 0;
  localparam int LINE_SEC = 1;
  localparam int LINE_MEM = 2;
  localparam int NUM_LINES = 3;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_HOLD, SEQ_SETTLE} seqState_t;

  typedef struct packed {
    logic                 load;
    logic [NUM_LINES-1:0] mask;
    logic                 release_;
    logic                 reinit;
    logic                 legClr;
    logic                 powerOff;
    logic                 sleepSet;
  } seqStrobes_t;
endpackage

// File: rtl/prc_ctrl.sv
module prc_ctrl
  import prc_pkg::*;
#(
  parameter int unsigned ASSERT_MS = 5,
  parameter int unsigned REINIT_MS = 100,
  parameter int unsigned DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              msTick,
  input  logic              legacyMode,
  output seqStrobes_t       strb,
  output logic              busy
);
  localparam int unsigned MAX_MS = (ASSERT_MS > REINIT_MS) ? ASSERT_MS : REINIT_MS;
  localparam int CNT_W = $clog2(MAX_MS + 1);
  localparam logic [CNT_W-1:0] HOLD_LAST   = CNT_W'(ASSERT_MS - 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(REINIT_MS - 1);

  seqState_t state;
  logic [CNT_W-1:0] tickCnt;

  always_comb begin
    strb = '0;
    strb.sleepSet = wrEn && wrData[BIT_SLEEP];
    case (state)
      SEQ_IDLE: if (wrEn) begin
        if (wrData[BIT_POFF]) begin
          strb.powerOff = 1'b1;
        end else if (wrData[BIT_FULL]) begin
          strb.load = 1'b1;
          strb.mask = '1;
        end else if (wrData[BIT_NORMAL]) begin
          strb.load = 1'b1;
          strb.mask[LINE_SEC] = 1'b1;
          strb.mask[LINE_MEM] = legacyMode;
          strb.legClr = 1'b1;
        end else if (wrData[BIT_MEM]) begin
          strb.load = 1'b1;
          strb.mask[LINE_MEM] = 1'b1;
        end
      end
      SEQ_HOLD:   strb.release_ = msTick && (tickCnt == HOLD_LAST);
      SEQ_SETTLE: strb.reinit   = msTick && (tickCnt == SETTLE_LAST);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= SEQ_IDLE;
      tickCnt <= '0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          tickCnt <= '0;
          if (strb.load) state <= SEQ_HOLD;
        end
        SEQ_HOLD: begin
          if (strb.release_) begin
            state   <= SEQ_SETTLE;
            tickCnt <= '0;
          end else if (msTick) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        SEQ_SETTLE: begin
          if (strb.reinit) begin
            state   <= SEQ_IDLE;
            tickCnt <= '0;
          end else if (msTick) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assign busy = (state != SEQ_IDLE);
endmodule

// File: rtl/prc_datapath.sv
module prc_datapath
  import prc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  seqStrobes_t strb,
  output logic        globalRstN,
  output logic        secRstN,
  output logic        secOe,
  output logic        memRstN,
  output logic        powerOffPulse,
  output logic        legacyClr,
  output logic        reinitPulse,
  output logic        sleepFlag
);
  logic [NUM_LINES-1:0] heldMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldMask      <= '0;
      powerOffPulse <= 1'b0;
      legacyClr     <= 1'b0;
      reinitPulse   <= 1'b0;
      sleepFlag     <= 1'b0;
    end else begin
      if (strb.load)          heldMask <= strb.mask;
      else if (strb.release_) heldMask <= '0;
      powerOffPulse <= strb.powerOff;
      legacyClr     <= strb.legClr;
      reinitPulse   <= strb.reinit;
      if (strb.sleepSet) sleepFlag <= 1'b1;
    end
  end

  assign globalRstN = ~heldMask[LINE_GLB];
  assign secRstN    = ~heldMask[LINE_SEC];
  assign secOe      =  heldMask[LINE_SEC];
  assign memRstN    = ~heldMask[LINE_MEM];
endmodule

// File: rtl/power_reset_seq.sv
module power_reset_seq
  import prc_pkg::*;
#(
  parameter int unsigned ASSERT_MS = 5,
  parameter int unsigned REINIT_MS = 100,
  parameter int unsigned DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic [DATA_W-1:0] ctrlWrData,
  input  logic              msTick,
  input  logic              legacyMode,
  output logic              globalRstN,
  output logic              secRstN,
  output logic              secOe,
  output logic              memRstN,
  output logic              powerOffPulse,
  output logic              legacyClr,
  output logic              reinitPulse,
  output logic              sleepFlag
);
  seqStrobes_t strb;
  logic seqBusy;

  prc_ctrl #(.ASSERT_MS(ASSERT_MS), .REINIT_MS(REINIT_MS), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(ctrlWrEn), .wrData(ctrlWrData),
    .msTick(msTick), .legacyMode(legacyMode), .strb(strb), .busy(seqBusy)
  );

  prc_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .globalRstN(globalRstN), .secRstN(secRstN), .secOe(secOe), .memRstN(memRstN),
    .powerOffPulse(powerOffPulse), .legacyClr(legacyClr),
    .reinitPulse(reinitPulse), .sleepFlag(sleepFlag)
  );
endmodule

// File: rtl/power_reset_seq_chk.sv
module power_reset_seq_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              ctrlWrEn,
  input logic [DATA_W-1:0] ctrlWrData,
  input logic              globalRstN,
  input logic              secRstN,
  input logic              memRstN,
  input logic              powerOffPulse,
  input logic              legacyClr,
  input logic              reinitPulse,
  input logic              seqBusy
);
  // R2: the global reset never stands alone
  assert_full_subset_R2: assert property (@(posedge clk) disable iff (!rstN)
    !globalRstN |-> (!secRstN && !memRstN));

  // R3: a legacy clear belongs to a normal reboot
  assert_legclr_sec_R3: assert property (@(posedge clk) disable iff (!rstN)
    legacyClr |-> (!secRstN && globalRstN));

  // R5: power off in idle gives the strobe and no reset
  assert_poweroff_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrEn && !seqBusy && ctrlWrData[0]) |=>
      (powerOffPulse && globalRstN && secRstN && memRstN));

  // R7: all lines leave reset in the same cycle
  assert_release_together_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memRstN) |-> (secRstN && globalRstN));

  // R8: the re-initialise strobe is one cycle wide and comes after the release
  assert_reinit_released_R8: assert property (@(posedge clk) disable iff (!rstN)
    reinitPulse |-> (globalRstN && secRstN && memRstN));
  assert_reinit_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    reinitPulse |=> !reinitPulse);

  // R9: a write while busy raises no strobe
  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrEn && seqBusy) |=> (!powerOffPulse && !legacyClr));
endmodule

bind power_reset_seq power_reset_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
  .globalRstN(globalRstN), .secRstN(secRstN), .memRstN(memRstN),
  .powerOffPulse(powerOffPulse), .legacyClr(legacyClr),
  .reinitPulse(reinitPulse), .seqBusy(seqBusy)
);

// File: tb/power_reset_seq_bench.sv
module power_reset_seq_bench;
  localparam int ASSERT_MS = 5;
  localparam int REINIT_MS = 100;
  localparam int NVEC = 10;
  // {data[7:0], legacy, expMask[2:0] (mem,sec,glb asserted), expPoff, expLegClr}
  localparam logic [13:0] VECS [NVEC] = '{
    {8'h02, 1'b0, 3'b111, 1'b0, 1'b0},
    {8'h04, 1'b0, 3'b010, 1'b0, 1'b1},
    {8'h04, 1'b1, 3'b110, 1'b0, 1'b1},
    {8'h08, 1'b0, 3'b100, 1'b0, 1'b0},
    {8'h06, 1'b1, 3'b111, 1'b0, 1'b0},
    {8'h0C, 1'b0, 3'b010, 1'b0, 1'b1},
    {8'h0C, 1'b1, 3'b110, 1'b0, 1'b1},
    {8'h0F, 1'b0, 3'b000, 1'b1, 1'b0},
    {8'h01, 1'b1, 3'b000, 1'b1, 1'b0},
    {8'hE0, 1'b0, 3'b000, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rstN = 1'b0, ctrlWrEn = 1'b0, msTick = 1'b0, legacyMode = 1'b0;
  logic [7:0] ctrlWrData = '0;
  logic globalRstN, secRstN, secOe, memRstN, powerOffPulse, legacyClr, reinitPulse, sleepFlag;
  int nRun = 0, nFail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  power_reset_seq #(.ASSERT_MS(ASSERT_MS), .REINIT_MS(REINIT_MS)) u_power_reset_seq (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .msTick(msTick), .legacyMode(legacyMode), .globalRstN(globalRstN),
    .secRstN(secRstN), .secOe(secOe), .memRstN(memRstN),
    .powerOffPulse(powerOffPulse), .legacyClr(legacyClr),
    .reinitPulse(reinitPulse), .sleepFlag(sleepFlag)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] lines();
    return {secOe, ~memRstN, ~secRstN, ~globalRstN};
  endfunction

  task automatic write(logic [7:0] d, logic leg);
    @(negedge clk);
    ctrlWrEn = 1'b1; ctrlWrData = d; legacyMode = leg;
    @(negedge clk);
    ctrlWrEn = 1'b0; ctrlWrData = '0;
  endtask

  task automatic tick();
    @(negedge clk); msTick = 1'b1;
    @(negedge clk); msTick = 1'b0;
  endtask

  task automatic runSequence(string req, logic [2:0] mask);
    for (int i = 0; i < ASSERT_MS - 1; i++) tick();
    check({req, " R7 held before last tick"}, lines(), {mask[1], mask});
    tick();
    check({req, " R7 released"}, lines(), 4'b0000);
    for (int i = 0; i < REINIT_MS - 1; i++) tick();
    check({req, " R8 no early reinit"}, reinitPulse, 1'b0);
    tick();
    check({req, " R8 reinit pulse"}, reinitPulse, 1'b1);
    @(negedge clk);
    check({req, " R8 reinit one cycle"}, reinitPulse, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset lines", lines(), 4'b0000);
    check("R1 reset strobes", {powerOffPulse, legacyClr, reinitPulse, sleepFlag}, 4'b0000);

    // table walk: R2 R3 R4 R5 R6 R10
    for (int v = 0; v < NVEC; v++) begin
      logic [2:0] m;
      m = VECS[v][4:2];
      write(VECS[v][13:6], VECS[v][5]);
      check($sformatf("R2/R3/R4/R6 vec%0d lines", v), lines(), {m[1], m});
      check($sformatf("R5 vec%0d poweroff", v), powerOffPulse, VECS[v][1]);
      check($sformatf("R3 vec%0d legclr", v), legacyClr, VECS[v][0]);
      if (m != 3'b000) runSequence($sformatf("vec%0d", v), m);
      else begin
        @(negedge clk);
        check($sformatf("R5 vec%0d one-cycle strobe", v), powerOffPulse, 1'b0);
      end
    end
    check("R10 upper bits no sleep", sleepFlag, 1'b0);

    // R9: requests while busy are ignored
    write(8'h08, 1'b0);
    check("R4 mem only", lines(), 4'b0100);
    write(8'h02, 1'b0);
    check("R9 full ignored in hold", lines(), 4'b0100);
    write(8'h01, 1'b0);
    check("R9 poweroff ignored in hold", powerOffPulse, 1'b0);
    for (int i = 0; i < ASSERT_MS; i++) tick();
    check("R7 released", lines(), 4'b0000);
    write(8'h04, 1'b1);
    check("R9 normal ignored in settle", {lines(), legacyClr}, 5'b00000);
    for (int i = 0; i < REINIT_MS; i++) tick();
    check("R8 reinit after ignored write", reinitPulse, 1'b1);
    write(8'h02, 1'b0);
    check("R9 accepted after idle", lines(), 4'b1111);
    runSequence("post-idle", 3'b111);

    // R10: sleep notice
    write(8'h10, 1'b0);
    check("R10 sleep flag set", sleepFlag, 1'b1);
    check("R10 no reset action", {lines(), powerOffPulse}, 5'b00000);
    repeat (3) @(negedge clk);
    check("R10 sleep flag sticky", sleepFlag, 1'b1);

    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule